// File: doc/BRIEF.md
# Gated-Clock Parallel-In Serial-Out Shift Register

This block is an eight-stage shift register that takes a parallel word and sends it out serially. It runs entirely on a fast system clock. The slow external shift clocks and control lines are treated as ordinary asynchronous inputs. Two interchangeable shift-clock inputs are ORed into one combined clock. Each rising edge of that combined clock moves the word one stage toward the output end, and the serial input fills the first stage. Holding either clock input high therefore gates the other one off.

An active-low load line copies the parallel word into the stages for as long as it is held low, and it takes priority over any shift. The last stage is driven out together with its complement. The four control lines (both clocks, load and serial input) each pass through a two-flop synchronizer. As a result, a change on any of them reaches the stages on the third system-clock rising edge after it is applied. The parallel data inputs are sampled directly and must be held stable while load is active.

Top module: `piso_gated_shreg`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, all stages and the clock-edge history are cleared, so `tail_out` is 0 and `tail_out_n` is 1 after reset.
- R2: While `load_n` is low, the stages take `par_in`. Bit `par_in[i]` goes to stage i; stage 0 is the first stage and stage N-1 drives `tail_out`.
- R3: While `load_n` is low, rising edges on either shift clock cause no shift. After `load_n` returns high, the stages still hold the loaded word.
- R4: With `load_n` high and `shift_clk_b` low, each rising edge of `shift_clk_a` moves stage i into stage i+1 and puts `serial_in` into stage 0.
- R5: While `shift_clk_b` is held high, pulses on `shift_clk_a` cause no shift.
- R6: With `shift_clk_a` low, a rising edge of `shift_clk_b` shifts exactly as in R4.
- R7: Each rising edge of the combined clock gives exactly one shift, however long the clock then stays high. A falling edge gives no shift.
- R8: `tail_out_n` is always the inverse of `tail_out`.
- R9: A rising edge on a shift clock changes `tail_out` on the third rising edge of `clk` after the input change, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_clk_a | input | 1 | Shift clock, asynchronous |
| shift_clk_b | input | 1 | Second shift clock, interchangeable with the first; acts as inhibit when held high |
| load_n | input | 1 | Active-low parallel load, level sensitive |
| serial_in | input | 1 | Data shifted into stage 0 |
| par_in | input | N (8) | Parallel word, bit i for stage i |
| tail_out | output | 1 | Last stage |
| tail_out_n | output | 1 | Complement of last stage |

## Verification
The shift path is driven three ways: by pulses on the first clock, by pulses on the second clock while the first is low, and by mixed sequences in which one clock is held high to gate the other. Loaded words with alternating and asymmetric bit patterns are shifted fully out while different serial bits are fed in. This distinguishes correct stage order and serial entry from reversed or stuck stages. Clock edges applied during load, long high clock levels and an exact cycle-by-cycle latency probe separate load priority, single-shift-per-edge and synchronizer depth from one another.

// File: rtl/piso_pkg.sv
package piso_pkg;
    localparam int CTRL_W = 4;

    typedef struct packed {
        logic serial;
        logic load_n;
        logic clk_b;
        logic clk_a;
    } ctrl_t;

    localparam ctrl_t CTRL_IDLE = '{serial: 1'b0, load_n: 1'b1, clk_b: 1'b0, clk_a: 1'b0};
endpackage

// File: rtl/sync_bank.sv
module sync_bank #(
    parameter int W = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.meta   = RST_VAL;
            st_d.stable = RST_VAL;
        end else begin
            st_d.meta   = async_in;
            st_d.stable = st_q.meta;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sync_out = st_q.stable;
endmodule

// File: rtl/rise_detect.sv
module rise_detect #(
    parameter int NCLK = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NCLK-1:0] clk_lvls,
    output logic            rise
);
    logic combined;
    logic prev_d, prev_q;

    assign combined = |clk_lvls;

    always_comb begin
        prev_d = rst ? 1'b0 : combined;
    end

    always_ff @(posedge clk) begin
        prev_q <= prev_d;
    end

    assign rise = combined & ~prev_q;
endmodule

// File: rtl/stage_chain.sv
module stage_chain #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         shift,
    input  logic         serial,
    input  logic [N-1:0] par,
    output logic [N-1:0] stages
);
    typedef struct packed {
        logic [N-1:0] stg;
    } chain_t;

    chain_t ch_d, ch_q;
    logic [N-1:0] shifted;

    generate
        for (genvar i = 0; i < N; i++) begin : g_stage
            if (i == 0) begin : g_head
                assign shifted[i] = serial;
            end else begin : g_body
                assign shifted[i] = ch_q.stg[i-1];
            end
        end
    endgenerate

    always_comb begin
        ch_d = ch_q;
        if (rst)        ch_d.stg = '0;
        else if (load)  ch_d.stg = par;
        else if (shift) ch_d.stg = shifted;
    end

    always_ff @(posedge clk) begin
        ch_q <= ch_d;
    end

    assign stages = ch_q.stg;
endmodule

// File: rtl/piso_gated_shreg.sv
module piso_gated_shreg
    import piso_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_clk_a,
    input  logic         shift_clk_b,
    input  logic         load_n,
    input  logic         serial_in,
    input  logic [N-1:0] par_in,
    output logic         tail_out,
    output logic         tail_out_n
);
    ctrl_t raw_ctrl, syn_ctrl;
    logic [CTRL_W-1:0] syn_vec;
    logic load_act;
    logic shift_ev;
    logic [N-1:0] stage_vec;

    assign raw_ctrl = '{serial: serial_in, load_n: load_n,
                        clk_b: shift_clk_b, clk_a: shift_clk_a};

    sync_bank #(.W(CTRL_W), .RST_VAL(CTRL_IDLE)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (raw_ctrl),
        .sync_out (syn_vec)
    );

    assign syn_ctrl = ctrl_t'(syn_vec);
    assign load_act = ~syn_ctrl.load_n;

    rise_detect #(.NCLK(2)) u_rise (
        .clk      (clk),
        .rst      (rst),
        .clk_lvls ({syn_ctrl.clk_b, syn_ctrl.clk_a}),
        .rise     (shift_ev)
    );

    stage_chain #(.N(N)) u_chain (
        .clk    (clk),
        .rst    (rst),
        .load   (load_act),
        .shift  (shift_ev),
        .serial (syn_ctrl.serial),
        .par    (par_in),
        .stages (stage_vec)
    );

    assign tail_out   = stage_vec[N-1];
    assign tail_out_n = ~stage_vec[N-1];
endmodule

// File: rtl/piso_gated_shreg_chk.sv
module piso_gated_shreg_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         load_act,
    input logic         shift_ev,
    input logic [N-1:0] stage_vec,
    input logic [N-1:0] par_in,
    input logic         tail_out,
    input logic         tail_out_n
);
    assert_complement_R8: assert property (@(posedge clk) disable iff (rst)
        tail_out_n == ~tail_out);

    assert_load_takes_word_R2: assert property (@(posedge clk) disable iff (rst)
        load_act |=> stage_vec == $past(par_in));

    assert_shift_moves_R4: assert property (@(posedge clk) disable iff (rst)
        (shift_ev && !load_act) |=> stage_vec[N-1:1] == $past(stage_vec[N-2:0]));

    assert_idle_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (!shift_ev && !load_act) |=> $stable(stage_vec));

    assert_one_shift_per_edge_R7: assert property (@(posedge clk) disable iff (rst)
        shift_ev |=> !shift_ev);
endmodule

bind piso_gated_shreg piso_gated_shreg_chk #(.N(N)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .load_act   (load_act),
    .shift_ev   (shift_ev),
    .stage_vec  (stage_vec),
    .par_in     (par_in),
    .tail_out   (tail_out),
    .tail_out_n (tail_out_n)
);

// File: tb/sim_piso_gated_shreg.sv
module sim_piso_gated_shreg;
    localparam int N = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ca = 1'b0, cb = 1'b0, ldn = 1'b1, sin = 1'b0;
    logic [N-1:0] par = '0;
    logic tail, tail_n;

    logic [N-1:0] mdl = '0;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    piso_gated_shreg #(.N(N)) u0 (
        .clk(clk), .rst(rst), .shift_clk_a(ca), .shift_clk_b(cb),
        .load_n(ldn), .serial_in(sin), .par_in(par),
        .tail_out(tail), .tail_out_n(tail_n)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    // apply control levels and update the reference from the requirements
    task automatic drive(input logic a, input logic b, input logic l, input logic s);
        logic was, now;
        was = ca | cb;
        now = a | b;
        @(negedge clk);
        ca = a; cb = b; ldn = l; sin = s;
        if (!l) mdl = par;
        else if (now && !was) mdl = {mdl[N-2:0], s};
        settle();
    endtask

    task automatic pulse_a(input logic s);
        drive(1'b1, cb, ldn, s);
        drive(1'b0, cb, ldn, s);
    endtask

    task automatic load_word(input logic [N-1:0] w);
        @(negedge clk);
        par = w;
        drive(ca, cb, 1'b0, sin);
        drive(ca, cb, 1'b1, sin);
    endtask

    // shifts the whole register out, checking every bit (R4 ordering)
    task automatic read_all(input string req, input logic [N-1:0] feed);
        for (int i = 0; i < N; i++) begin
            check(req, tail, mdl[N-1]);
            check("R8", tail_n, ~mdl[N-1]);
            pulse_a(feed[i]);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 tail", tail, 1'b0);
        check("R1 tail_n", tail_n, 1'b1);
    endtask

    task automatic t_load_shift();
        load_word(8'hA5);
        check("R2", tail, 1'b1);
        read_all("R2/R4", 8'b1100_1010);
        read_all("R4 serial", 8'h00);
    endtask

    task automatic t_load_override();
        load_word(8'h3C);
        @(negedge clk);
        par = 8'h81;
        drive(ca, cb, 1'b0, 1'b0);
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        check("R3 during load", tail, 1'b1);
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        drive(1'b0, 1'b1, 1'b0, 1'b0);
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        drive(1'b0, 1'b0, 1'b1, 1'b0);
        check("R3 held word", tail, 1'b1);
        read_all("R3 no shift", 8'h00);
    endtask

    task automatic t_inhibit();
        load_word(8'h96);
        drive(1'b1, 1'b0, 1'b1, 1'b1);
        drive(1'b1, 1'b1, 1'b1, 1'b0);
        drive(1'b0, 1'b1, 1'b1, 1'b0);
        for (int k = 0; k < 3; k++) begin
            pulse_a(1'b1);
            check("R5 inhibited", tail, mdl[N-1]);
        end
        drive(1'b1, 1'b1, 1'b1, 1'b0);
        drive(1'b1, 1'b0, 1'b1, 1'b0);
        drive(1'b0, 1'b0, 1'b1, 1'b0);
        read_all("R5 contents", 8'h0F);
    endtask

    task automatic t_clk_b();
        load_word(8'h4E);
        for (int k = 0; k < N; k++) begin
            check("R6", tail, mdl[N-1]);
            drive(1'b0, 1'b1, 1'b1, k[0]);
            drive(1'b0, 1'b0, 1'b1, k[0]);
        end
        read_all("R6 serial", 8'h00);
    endtask

    task automatic t_hold();
        load_word(8'b1010_1010);
        @(negedge clk);
        ca = 1'b1;
        mdl = {mdl[N-2:0], sin};
        repeat (20) @(posedge clk);
        @(negedge clk);
        check("R7 single shift", tail, 1'b0);
        drive(1'b0, 1'b0, 1'b1, sin);
        check("R7 fall no shift", tail, mdl[N-1]);
        read_all("R7 contents", 8'h00);
    endtask

    task automatic t_latency();
        load_word(8'h7F);
        @(negedge clk);
        ca = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        check("R9 two edges", tail, 1'b0);
        @(posedge clk); #1;
        check("R9 third edge", tail, 1'b1);
        mdl = {mdl[N-2:0], sin};
        drive(1'b0, 1'b0, 1'b1, sin);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_load_shift();
        t_load_override();
        t_inhibit();
        t_clk_b();
        t_hold();
        t_latency();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule